// File: doc/BRIEF.md
# Two-Plane Monochrome Cursor Overlay

This block lays a 16×16 two-colour pointer over a 24-bit pixel stream. The pointer image lives in video memory inside a region aligned to 1 KB. Each of the 16 image rows takes 16 bytes. Bytes 0 and 1 of a row hold the XOR plane. Bytes 8 and 9 hold the AND plane, stored inverted, so a stored 1 marks an opaque pixel. Software sets up the block through a write-only register port: the image base, the X and Y screen position of the top-left pixel, the two colours and an enable bit.

On the pixel side, the video timing supplies the beam coordinates, a horizontal-blank flag, a frame-start pulse and the incoming pixel. The block returns the outgoing pixel one cycle later. The beam Y value moves to the next line when that line's leading blank begins. During that blank, the block issues at most one 4-byte read of the image row that the coming line needs. The memory side gathers bytes 0, 1, 8 and 9 into one word. The returned row sits in a small internal buffer until the next blank. The position registers take effect only at frame start, so the pointer never tears in the middle of a frame.

Register select values: 0 is control (bit 0 is the enable), 1 is the image base, 2 is X, 3 is Y, 4 is the foreground colour, 5 is the background colour.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, `pix_out` is 0 and `fetch_req` is 0.
- R2: For a covered pixel, the stored AND bit `a` and the XOR bit `x` select the output: a=0,x=0 passes the input pixel; a=0,x=1 gives its bitwise inverse; a=1,x=0 gives the background colour; a=1,x=1 gives the foreground colour.
- R3: `fetch_data` carries byte 0 in bits 7:0, byte 1 in 15:8, byte 8 in 23:16 and byte 9 in 31:24. Column c of the pointer (0 = leftmost) takes its bits from byte 0 / byte 8 for c<8, or from byte 1 / byte 9 for c≥8, at bit position 7−(c mod 8).
- R4: The image base register is decoded to kb = {reg[12], reg[7:0], reg[11:8]}. The read for pointer row r has address kb·1024 + 16·r.
- R5: Exactly one read is issued, and completed once, for each line whose beam Y lies in [Y, Y+15] while the block is enabled. No read is issued for any other line.
- R6: Writes to X and Y take effect only at a `frame_start` pulse. Until the pulse, the pointer stays at its previous position.
- R7: Clearing control bit 0 hides the pointer from the next pixel on: every output then equals the input pixel of the cycle before.
- R8: After reset, the foreground colour is 0xFFFFFF and the background colour is 0x000000.
- R9: Pixels with `hblank` high, and pixels outside the 16×16 window, pass through unchanged.
- R10: If the read has not completed by the end of the blank, it is withdrawn. `fetch_req` is low in active video, and that line shows no pointer.
- R11: `pix_out` is registered: it reflects the inputs of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 24 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| hblank | input | 1 | Horizontal blank, high before each line |
| beam_x | input | 12 | Current beam column |
| beam_y | input | 12 | Current/upcoming beam line |
| pix_in | input | 24 | Incoming pixel |
| pix_out | output | 24 | Outgoing pixel, one cycle later |
| fetch_req | output | 1 | Row read request, held until acknowledged |
| fetch_addr | output | 23 | Byte address of the requested row |
| fetch_ack | input | 1 | Read completion, with data valid |
| fetch_data | input | 32 | Gathered row bytes 0, 1, 8, 9 |

## Verification
The assertions assume that `fetch_ack` is raised only while `fetch_req` is high. They also assume that `beam_y` holds still for a whole blank and the line after it. The bench's memory model answers only a visible request and drops its acknowledge once the request falls. Every line is driven as one blank with a fixed `beam_y`, followed by a column sweep. The checks on pass-through under blanking and disable assume that `pix_in` is a free input that the block must not alter in those cycles.

// File: rtl/cursor_pkg.sv
// Shared constants and the register select encoding for the cursor overlay.
// Assumes the image format is fixed at 16x16 pixels with 16-byte rows.
package cursor_pkg;
    localparam int CUR_DIM  = 16;             // pointer width and height
    localparam int ROW_SH   = 4;              // log2 of bytes per image row
    localparam int KB_W     = 13;             // width of the base, in KB units
    localparam int ADDR_W   = KB_W + 10;      // byte address width
    localparam int PIX_W    = 24;             // pixel and colour width

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_BASE = 3'd1,
        SEL_POSX = 3'd2,
        SEL_POSY = 3'd3,
        SEL_FG   = 3'd4,
        SEL_BG   = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/cursor_regs.sv
// Register file of the cursor overlay. Holds the enable bit, the image base
// (decoded out of its shuffled layout), both colours and the position.
// Position writes are shadowed and copied to the live values at frame start.
// Assumes reg_wdata is at least as wide as every field.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [PIX_W-1:0]   reg_wdata,
    input  logic               frame_start,
    output logic               cur_en,
    output logic [KB_W-1:0]    base_kb,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic [PIX_W-1:0]   col_fg,
    output logic [PIX_W-1:0]   col_bg
);
    logic [KB_W-1:0]    base_raw;
    logic [COORD_W-1:0] shadow_x;
    logic [COORD_W-1:0] shadow_y;

    // Un-shuffle the stored base: low nibble of the KB index sits in 11:8
    assign base_kb = {base_raw[12], base_raw[7:0], base_raw[11:8]};

    // Accept register writes and copy the position at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_en   <= 1'b0;
            base_raw <= '0;
            shadow_x <= '0;
            shadow_y <= '0;
            pos_x    <= '0;
            pos_y    <= '0;
            col_fg   <= {PIX_W{1'b1}};
            col_bg   <= '0;
        end else begin
            if (reg_we) begin
                case (reg_sel_e'(reg_addr))
                    SEL_CTRL: cur_en   <= reg_wdata[0];
                    SEL_BASE: base_raw <= reg_wdata[KB_W-1:0];
                    SEL_POSX: shadow_x <= reg_wdata[COORD_W-1:0];
                    SEL_POSY: shadow_y <= reg_wdata[COORD_W-1:0];
                    SEL_FG:   col_fg   <= reg_wdata;
                    SEL_BG:   col_bg   <= reg_wdata;
                    default:  ;
                endcase
            end
            if (frame_start) begin
                pos_x <= shadow_x;
                pos_y <= shadow_y;
            end
        end
    end

    // R6
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(pos_x) && $stable(pos_y)));
endmodule

// File: rtl/cursor_fetch.sv
// Row fetcher and one-row buffer. At the rising edge of the horizontal
// blank it decides whether the coming line crosses the pointer and, if so,
// requests that image row. The request is visible only during the blank; a
// read that has not completed by the end of the blank is dropped.
// Assumes beam_y already names the coming line when the blank begins, and
// that fetch_ack is raised only while fetch_req is high.
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_en,
    input  logic [KB_W-1:0]    base_kb,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COORD_W-1:0] beam_y,
    input  logic               hblank,
    input  logic               fetch_ack,
    input  logic [31:0]        fetch_data,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic [CUR_DIM-1:0] row_xor,
    output logic [CUR_DIM-1:0] row_and,
    output logic               row_valid
);
    localparam int ROW_IW = $clog2(CUR_DIM);

    logic               hblank_q;
    logic               req_q;
    logic [COORD_W-1:0] row_off;
    logic               on_cursor;

    assign row_off   = beam_y - pos_y;
    assign on_cursor = cur_en && (row_off < COORD_W'(CUR_DIM));
    assign fetch_req = req_q && hblank;

    // Start a read at blank entry, capture its data, drop it at blank exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_q   <= 1'b0;
            req_q      <= 1'b0;
            fetch_addr <= '0;
            row_xor    <= '0;
            row_and    <= '0;
            row_valid  <= 1'b0;
        end else begin
            hblank_q <= hblank;
            if (hblank && !hblank_q) begin
                row_valid  <= 1'b0;
                req_q      <= on_cursor;
                fetch_addr <= {base_kb, {(10-ROW_IW-ROW_SH){1'b0}},
                               row_off[ROW_IW-1:0], {ROW_SH{1'b0}}};
            end else if (fetch_req && fetch_ack) begin
                row_xor   <= {fetch_data[7:0],   fetch_data[15:8]};
                row_and   <= {fetch_data[23:16], fetch_data[31:24]};
                row_valid <= 1'b1;
                req_q     <= 1'b0;
            end else if (!hblank) begin
                req_q <= 1'b0;
            end
        end
    end

    // R5
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && hblank) |=> !fetch_req);

    // R4
    row_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> (fetch_addr[9:8] == 2'b00 && fetch_addr[3:0] == 4'h0));

    // R10
    late_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !hblank) |=> !req_q);
endmodule

// File: rtl/cursor_blend.sv
// Per-pixel mixer. Decides whether the beam lies inside the pointer window
// on a line with a buffered row, picks the two plane bits for the column and
// registers the mixed pixel. Assumes byte 0/8 hold the left eight columns
// with the most significant bit leftmost.
module cursor_blend
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_en,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] beam_x,
    input  logic               hblank,
    input  logic               row_valid,
    input  logic [CUR_DIM-1:0] row_xor,
    input  logic [CUR_DIM-1:0] row_and,
    input  logic [PIX_W-1:0]   col_fg,
    input  logic [PIX_W-1:0]   col_bg,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [PIX_W-1:0]   pix_out
);
    localparam int COL_IW = $clog2(CUR_DIM);

    logic [COORD_W-1:0] col;
    logic [COL_IW-1:0]  bit_idx;
    logic               hit;
    logic [PIX_W-1:0]   mixed;

    assign col     = beam_x - pos_x;
    assign bit_idx = ~col[COL_IW-1:0];
    assign hit     = cur_en && row_valid && !hblank && (col < COORD_W'(CUR_DIM));

    // Apply the two-plane rule to the current pixel
    always_comb begin
        mixed = pix_in;
        if (hit) begin
            case ({row_and[bit_idx], row_xor[bit_idx]})
                2'b00:   mixed = pix_in;
                2'b01:   mixed = ~pix_in;
                2'b10:   mixed = col_bg;
                default: mixed = col_fg;
            endcase
        end
    end

    // Register the outgoing pixel
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= mixed;
    end

    // R7
    hidden_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |=> (pix_out == $past(pix_in)));

    // R9
    blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |=> (pix_out == $past(pix_in)));
endmodule

// File: rtl/cursor_overlay.sv
// Top of the two-plane cursor overlay: register file, row fetcher and
// pixel mixer. Assumes the timing source moves beam_y to the coming line
// when that line's leading blank starts.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [2:0]            reg_addr,
    input  logic [23:0]           reg_wdata,
    input  logic                  frame_start,
    input  logic                  hblank,
    input  logic [COORD_W-1:0]    beam_x,
    input  logic [COORD_W-1:0]    beam_y,
    input  logic [23:0]           pix_in,
    output logic [23:0]           pix_out,
    output logic                  fetch_req,
    output logic [22:0]           fetch_addr,
    input  logic                  fetch_ack,
    input  logic [31:0]           fetch_data
);
    logic               cur_en;
    logic [KB_W-1:0]    base_kb;
    logic [COORD_W-1:0] pos_x;
    logic [COORD_W-1:0] pos_y;
    logic [PIX_W-1:0]   col_fg;
    logic [PIX_W-1:0]   col_bg;
    logic [CUR_DIM-1:0] row_xor;
    logic [CUR_DIM-1:0] row_and;
    logic               row_valid;

    cursor_regs #(.COORD_W(COORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .cur_en(cur_en),
        .base_kb(base_kb), .pos_x(pos_x), .pos_y(pos_y),
        .col_fg(col_fg), .col_bg(col_bg)
    );

    cursor_fetch #(.COORD_W(COORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .base_kb(base_kb),
        .pos_y(pos_y), .beam_y(beam_y), .hblank(hblank),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .row_xor(row_xor), .row_and(row_and), .row_valid(row_valid)
    );

    cursor_blend #(.COORD_W(COORD_W)) u_blend (
        .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .pos_x(pos_x),
        .beam_x(beam_x), .hblank(hblank), .row_valid(row_valid),
        .row_xor(row_xor), .row_and(row_and), .col_fg(col_fg),
        .col_bg(col_bg), .pix_in(pix_in), .pix_out(pix_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pix_out == '0 && !fetch_req));
endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        hblank = 1'b0;
    logic [11:0] beam_x = '0;
    logic [11:0] beam_y = '0;
    logic [23:0] pix_in = '0;
    logic [23:0] pix_out;
    logic        fetch_req;
    logic [22:0] fetch_addr;
    logic        fetch_ack;
    logic [31:0] fetch_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    bit  b_en = 0;
    int  b_px = 0, b_py = 0, b_cx = 0, b_cy = 0;
    int  b_kb = 0;
    logic [23:0] b_fg = 24'hFFFFFF, b_bg = 24'h000000;
    bit  b_row_ok = 0;
    bit  mem_on = 1;
    int  fetch_cnt = 0;
    logic [22:0] last_addr = '0;

    always #2.5 clk = ~clk;

    cursor_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .hblank(hblank),
        .beam_x(beam_x), .beam_y(beam_y), .pix_in(pix_in), .pix_out(pix_out),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .fetch_data(fetch_data)
    );

    function automatic logic [15:0] and_row(int r);
        return 16'hFF00 ^ 16'(r << 2);
    endfunction
    function automatic logic [15:0] xor_row(int r);
        return 16'hF0F0 ^ 16'(r);
    endfunction

    // memory model: byte0 = xor[15:8], byte1 = xor[7:0], byte8 = and[15:8], byte9 = and[7:0]
    always_comb begin
        logic [15:0] a, x;
        a = and_row(int'(fetch_addr[7:4]));
        x = xor_row(int'(fetch_addr[7:4]));
        fetch_data = {a[7:0], a[15:8], x[7:0], x[15:8]};
    end

    logic ack_q;
    assign fetch_ack = ack_q;
    always @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= fetch_req && !ack_q && mem_on;
        if (rst_n && fetch_req && ack_q) begin
            fetch_cnt <= fetch_cnt + 1;
            last_addr <= fetch_addr;
        end
    end

    function automatic logic [23:0] pat(int x, int y);
        return {8'(x), 8'(y), 8'hA5};
    endfunction

    function automatic logic [23:0] exp_pix(int x, int y, logic [23:0] pin);
        int c, r;
        logic [15:0] a, xr;
        c = x - b_cx;
        r = y - b_cy;
        if (!b_en || !b_row_ok || c < 0 || c > 15 || r < 0 || r > 15) return pin;
        a  = and_row(r);
        xr = xor_row(r);
        case ({a[15-c], xr[15-c]})
            2'b00:   return pin;
            2'b01:   return ~pin;
            2'b10:   return b_bg;
            default: return b_fg;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [23:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            3'd0: b_en = d[0];
            3'd1: b_kb = int'({d[12], d[7:0], d[11:8]});
            3'd2: b_px = int'(d[11:0]);
            3'd3: b_py = int'(d[11:0]);
            3'd4: b_fg = d;
            3'd5: b_bg = d;
            default: ;
        endcase
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        b_cx = b_px; b_cy = b_py;
    endtask

    // blank before line y: checks pass-through (R9), read count (R5), address (R4), drop (R10)
    task automatic do_blank(int y, bit chk_addr);
        int c0, r, expn;
        r = y - b_cy;
        expn = (b_en && r >= 0 && r < 16) ? 1 : 0;
        b_row_ok = (expn == 1) && mem_on;
        c0 = fetch_cnt;
        beam_y = 12'(y);
        beam_x = 12'(b_cx + 3);
        hblank = 1'b1;
        for (int i = 0; i < 8; i++) begin
            pix_in = pat(i, y);
            @(negedge clk);
            chk("R9 blank pass", pix_out, pat(i, y));
        end
        hblank = 1'b0;
        #1;
        chk("R10 no request in active video", fetch_req, 0);
        chk("R5 reads for line", fetch_cnt - c0, mem_on ? expn : 0);
        if (chk_addr && expn == 1 && mem_on)
            chk("R4 row address", last_addr, 32'(b_kb * 1024 + r * 16));
    endtask

    task automatic do_pixels(int y, int x0, int x1, string tag);
        logic [23:0] e;
        for (int x = x0; x <= x1; x++) begin
            beam_x = 12'(x);
            pix_in = pat(x, y);
            e = exp_pix(x, y, pix_in);
            @(negedge clk);
            chk(tag, pix_out, e);
        end
    endtask

    task automatic t_reset();
        pix_in = 24'h123456;
        repeat (3) @(negedge clk);
        chk("R1 pix_out in reset", pix_out, 0);
        chk("R1 fetch_req in reset", fetch_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_defaults();
        wr(3'd0, 24'h1);
        wr(3'd2, 24'd10);
        wr(3'd3, 24'd20);
        wr(3'd1, 24'h0003);
        frame();
        for (int y = 18; y <= 37; y++) begin
            do_blank(y, 1'b1);
            do_pixels(y, 0, 40, "R2 R3 R8 R11 mix default colours");
        end
    endtask

    task automatic t_colours();
        wr(3'd4, 24'h00FF00);
        wr(3'd5, 24'h112233);
        do_blank(25, 1'b0);
        do_pixels(25, 5, 30, "R2 programmed colours");
        do_blank(34, 1'b0);
        do_pixels(34, 5, 30, "R2 R3 last rows");
    endtask

    task automatic t_base();
        wr(3'd1, 24'h001A5C);
        do_blank(22, 1'b1);
        do_pixels(22, 8, 28, "R4 shape at new base");
        do_blank(35, 1'b1);
    endtask

    task automatic t_position();
        wr(3'd2, 24'd100);
        wr(3'd3, 24'd50);
        do_blank(22, 1'b0);
        do_pixels(22, 0, 30, "R6 old position kept");
        frame();
        do_blank(22, 1'b0);
        do_pixels(22, 0, 30, "R6 old position gone");
        do_blank(55, 1'b1);
        do_pixels(55, 90, 120, "R6 new position");
    endtask

    task automatic t_enable();
        do_blank(56, 1'b0);
        do_pixels(56, 95, 110, "R7 before disable");
        wr(3'd0, 24'h0);
        do_pixels(56, 95, 120, "R7 hidden after clear");
        do_blank(57, 1'b0);
        do_pixels(57, 95, 120, "R7 no read when disabled");
        wr(3'd0, 24'h1);
    endtask

    task automatic t_late();
        mem_on = 0;
        do_blank(58, 1'b0);
        do_pixels(58, 95, 120, "R10 dropped read shows nothing");
        mem_on = 1;
        repeat (2) @(negedge clk);
        do_blank(59, 1'b1);
        do_pixels(59, 95, 120, "R10 recovery next line");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_defaults();
        t_colours();
        t_base();
        t_position();
        t_enable();
        t_late();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule